// File: doc/BRIEF.md
# Masked Repeating Alarm Controller

This block watches a calendar clock and raises an alarm when the current time agrees with a stored alarm time on a chosen set of digits. It does not keep time. It receives the current half-second flag, seconds, minutes, hours, weekday, day and month as BCD digits, together with a strobe that marks each advance of that clock. A 4-bit mask code selects the alarm interval. The interval can be as short as every half second or as long as once a year.

Alarm events are counted down by an 8-bit repeat counter. After the final permitted event the controller disarms itself. In chime mode the counter instead wraps from zero to its top value, and alarms continue without end. Each event produces a one-cycle interrupt pulse. Each event also flips a level output, so that output runs at half the alarm rate. Software writes the configuration (enable, mask, repeat count, chime) at any time. It writes the alarm time only while the alarm is disarmed.

The sequencing is a two-state machine:

- `ST_OFF` moves to `ST_ARMED` on a configuration write with the enable bit set.
- `ST_ARMED` moves to `ST_OFF` on a configuration write with the enable bit clear, or on the final event when chime is off.
- In every other case `ST_ARMED` holds its state.

Top module: `rpt_alarm`

## Requirements
- R1: While reset is asserted, the outputs are held at these values: `en_o` = 0, `rpt_o` = 0x00, `irq` = 0 and `alm_pulse` = 0.
- R2: An event occurs at a clock edge where the alarm is armed, `tick` is high and the mask condition holds. `irq` is high for exactly the one cycle that follows that edge.
- R3: The mask code selects the fields that must agree with the alarm time. In every code except 0000, the half-second flag must be 0.
  - 0000: no condition, so every tick matches.
  - 0001: only the half-second condition.
  - 0010: also the seconds ones digit.
  - 0011: the full seconds value.
  - 0100: also the minutes ones digit.
  - 0101: the full minutes value.
  - 0110: also the hours.
  - 0111: also the weekday.
  - 1000: seconds, minutes, hours and day; the weekday is ignored.
  - 1001: as 1000, plus the month.
- R4: Mask codes 1010 through 1111 never produce an event.
- R5: An event that finds the repeat count nonzero decrements it by one.
- R6: An event that finds the count at 0x00 with chime off is the last event. It clears `en_o`, and `rpt_o` stays 0x00.
- R7: An event that finds the count at 0x00 with chime on loads 0xFF. The alarm stays armed.
- R8: `alm_pulse` inverts on every event that leaves the alarm armed. It is 0 whenever the alarm is disarmed, including after the final event, and it starts at 0 when the alarm is armed.
- R9: An alarm-time write (`set_wr`) while armed is ignored. A write while disarmed replaces the stored alarm time.
- R10: A configuration write (`cfg_wr`) is accepted in either state. It loads the enable, mask, repeat count and chime values, and `rpt_o` shows the new count in the next cycle.
- R11: No event occurs without `tick`. A matching time held over several cycles gives one event per tick, never more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-advance strobe; the comparison is made only on this cycle |
| now_half | input | 1 | Current half-second flag (1 = second half) |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_wday | input | 3 | Current weekday |
| now_day | input | 8 | Current day of month, BCD |
| now_month | input | 8 | Current month, BCD |
| set_wr | input | 1 | Alarm-time write strobe |
| set_sec | input | 8 | Alarm seconds, BCD |
| set_min | input | 8 | Alarm minutes, BCD |
| set_hour | input | 8 | Alarm hours, BCD |
| set_wday | input | 3 | Alarm weekday |
| set_day | input | 8 | Alarm day, BCD |
| set_month | input | 8 | Alarm month, BCD |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable value to load |
| cfg_mask | input | 4 | Mask code to load |
| cfg_rpt | input | 8 | Repeat count to load |
| cfg_chime | input | 1 | Chime mode to load |
| irq | output | 1 | One-cycle interrupt pulse per event |
| alm_pulse | output | 1 | Level output that inverts on each event |
| en_o | output | 1 | Live enable |
| rpt_o | output | 8 | Live repeat count |

## Verification
Every result is registered once. An input that is sampled at a clock edge (a tick, a configuration write or an alarm-time write) therefore shows its effect on `irq`, `alm_pulse`, `en_o` and `rpt_o` immediately after that same edge. The bench drives inputs a quarter period after the rising edge. The behavioural model updates at the edge from the same stable inputs. All four outputs are compared with the model at the falling edge, which is the first point where the edge's effect is visible. Directed checks read their fixed expected counts and levels after that falling edge, so a result that comes a cycle late, or lasts a cycle too long, shows up as a mismatch.

// File: rtl/rpt_alarm_pkg.sv
package rpt_alarm_pkg;

    localparam int BCD_W  = 8;
    localparam int WDAY_W = 3;
    localparam int NFIELD = 9;

    typedef struct packed {
        logic              half;
        logic [BCD_W-1:0]  sec;
        logic [BCD_W-1:0]  min;
        logic [BCD_W-1:0]  hour;
        logic [WDAY_W-1:0] wday;
        logic [BCD_W-1:0]  day;
        logic [BCD_W-1:0]  month;
    } now_t;

    typedef struct packed {
        logic [BCD_W-1:0]  sec;
        logic [BCD_W-1:0]  min;
        logic [BCD_W-1:0]  hour;
        logic [WDAY_W-1:0] wday;
        logic [BCD_W-1:0]  day;
        logic [BCD_W-1:0]  month;
    } atime_t;

    typedef enum logic [0:0] {
        ST_OFF   = 1'b0,
        ST_ARMED = 1'b1
    } alm_state_t;

endpackage

// File: rtl/rpt_alarm_cmp.sv
module rpt_alarm_cmp
    import rpt_alarm_pkg::*;
#(
    parameter int MASK_W = 4
) (
    input  now_t              now,
    input  atime_t            ref_t,
    input  logic [MASK_W-1:0] code,
    output logic              hit
);

    localparam int LAST_CODE = 9;
    localparam int N_THERMO  = 6;

    logic [NFIELD-1:0] eq;
    logic [NFIELD-1:0] need;
    logic              legal;
    int                cval;

    assign cval  = int'(code);
    assign legal = (cval <= LAST_CODE);

    // Field order: half, sec lo, sec hi, min lo, min hi, hour, wday, day, month
    assign eq[0] = ~now.half;
    assign eq[1] = (now.sec[3:0]   == ref_t.sec[3:0]);
    assign eq[2] = (now.sec[7:4]   == ref_t.sec[7:4]);
    assign eq[3] = (now.min[3:0]   == ref_t.min[3:0]);
    assign eq[4] = (now.min[7:4]   == ref_t.min[7:4]);
    assign eq[5] = (now.hour       == ref_t.hour);
    assign eq[6] = (now.wday       == ref_t.wday);
    assign eq[7] = (now.day        == ref_t.day);
    assign eq[8] = (now.month      == ref_t.month);

    // The first six fields form a thermometer over the code value
    for (genvar i = 0; i < N_THERMO; i++) begin : g_thermo
        assign need[i] = legal && (cval > i);
    end

    assign need[6] = (cval == 7);
    assign need[7] = legal && (cval >= 8);
    assign need[8] = (cval == LAST_CODE);

    assign hit = legal && (&(eq | ~need));

endmodule

// File: rtl/rpt_alarm_vreg.sv
module rpt_alarm_vreg
    import rpt_alarm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   armed,
    input  logic   wr,
    input  atime_t wdata,
    output atime_t q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr && !armed) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/rpt_alarm_seq.sv
module rpt_alarm_seq
    import rpt_alarm_pkg::*;
#(
    parameter int MASK_W = 4,
    parameter int RPT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hit,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic [MASK_W-1:0] cfg_mask,
    input  logic [RPT_W-1:0]  cfg_rpt,
    input  logic              cfg_chime,
    output logic              armed,
    output logic [MASK_W-1:0] mask_q,
    output logic              chime_q,
    output logic [RPT_W-1:0]  rpt_q,
    output logic              irq,
    output logic              pulse
);

    localparam logic [RPT_W-1:0] RPT_TOP = {RPT_W{1'b1}};
    localparam logic [RPT_W-1:0] RPT_ONE = RPT_W'(1);

    alm_state_t state, state_nx;
    logic       fire;
    logic       last;

    assign fire  = (state == ST_ARMED) && tick && hit;
    assign last  = fire && (rpt_q == '0) && !chime_q;
    assign armed = (state == ST_ARMED);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (cfg_wr && cfg_en) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (cfg_wr)    state_nx = cfg_en ? ST_ARMED : ST_OFF;
                else if (last) state_nx = ST_OFF;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            pulse   <= 1'b0;
            rpt_q   <= '0;
            mask_q  <= '0;
            chime_q <= 1'b0;
        end else begin
            irq <= fire;

            if (cfg_wr) begin
                rpt_q   <= cfg_rpt;
                mask_q  <= cfg_mask;
                chime_q <= cfg_chime;
            end else if (fire) begin
                if (rpt_q != '0) rpt_q <= rpt_q - RPT_ONE;
                else if (chime_q) rpt_q <= RPT_TOP;
            end

            unique case (state)
                ST_OFF:   pulse <= 1'b0;
                ST_ARMED: begin
                    if (state_nx == ST_OFF) pulse <= 1'b0;
                    else if (fire)          pulse <= ~pulse;
                end
                default:  pulse <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/rpt_alarm.sv
module rpt_alarm
    import rpt_alarm_pkg::*;
#(
    parameter int MASK_W = 4,
    parameter int RPT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              now_half,
    input  logic [7:0]        now_sec,
    input  logic [7:0]        now_min,
    input  logic [7:0]        now_hour,
    input  logic [2:0]        now_wday,
    input  logic [7:0]        now_day,
    input  logic [7:0]        now_month,
    input  logic              set_wr,
    input  logic [7:0]        set_sec,
    input  logic [7:0]        set_min,
    input  logic [7:0]        set_hour,
    input  logic [2:0]        set_wday,
    input  logic [7:0]        set_day,
    input  logic [7:0]        set_month,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic [MASK_W-1:0] cfg_mask,
    input  logic [RPT_W-1:0]  cfg_rpt,
    input  logic              cfg_chime,
    output logic              irq,
    output logic              alm_pulse,
    output logic              en_o,
    output logic [RPT_W-1:0]  rpt_o
);

    now_t              now_v;
    atime_t            set_v;
    atime_t            val_q;
    logic [MASK_W-1:0] mask_q;
    logic              chime_q;
    logic              hit;
    logic              armed;

    assign now_v = '{half: now_half, sec: now_sec, min: now_min, hour: now_hour,
                     wday: now_wday, day: now_day, month: now_month};
    assign set_v = '{sec: set_sec, min: set_min, hour: set_hour,
                     wday: set_wday, day: set_day, month: set_month};

    rpt_alarm_vreg u_vreg (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (armed),
        .wr    (set_wr),
        .wdata (set_v),
        .q     (val_q)
    );

    rpt_alarm_cmp #(.MASK_W(MASK_W)) u_cmp (
        .now   (now_v),
        .ref_t (val_q),
        .code  (mask_q),
        .hit   (hit)
    );

    rpt_alarm_seq #(.MASK_W(MASK_W), .RPT_W(RPT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hit       (hit),
        .cfg_wr    (cfg_wr),
        .cfg_en    (cfg_en),
        .cfg_mask  (cfg_mask),
        .cfg_rpt   (cfg_rpt),
        .cfg_chime (cfg_chime),
        .armed     (armed),
        .mask_q    (mask_q),
        .chime_q   (chime_q),
        .rpt_q     (rpt_o),
        .irq       (irq),
        .pulse     (alm_pulse)
    );

    assign en_o = armed;

endmodule

// File: rtl/rpt_alarm_chk.sv
module rpt_alarm_chk
    import rpt_alarm_pkg::*;
#(
    parameter int RPT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cfg_wr,
    input logic             irq,
    input logic             alm_pulse,
    input logic             en_o,
    input logic [RPT_W-1:0] rpt_o,
    input logic             chime_q,
    input atime_t           val_q
);

    // R1: outputs idle while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r1: assert (!irq && !alm_pulse && !en_o && rpt_o == '0)
                else $error("reset outputs not idle");
        end
    end

    p_irq_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en_o));

    p_no_tick_no_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !irq);

    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(cfg_wr) && $past(rpt_o) != '0) |-> (rpt_o == $past(rpt_o) - RPT_W'(1)));

    p_final_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(cfg_wr) && $past(rpt_o) == '0 && !$past(chime_q)) |-> (!en_o && rpt_o == '0));

    p_chime_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(cfg_wr) && $past(rpt_o) == '0 && $past(chime_q)) |-> (en_o && rpt_o == '1));

    p_pulse_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |-> !alm_pulse);

    p_pulse_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && en_o && $past(en_o) && !$past(cfg_wr)) |-> (alm_pulse != $past(alm_pulse)));

    p_value_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> $stable(val_q));

endmodule

bind rpt_alarm rpt_alarm_chk #(.RPT_W(RPT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cfg_wr    (cfg_wr),
    .irq       (irq),
    .alm_pulse (alm_pulse),
    .en_o      (en_o),
    .rpt_o     (rpt_o),
    .chime_q   (chime_q),
    .val_q     (val_q)
);

// File: tb/rpt_alarm_bench.sv
`timescale 1ns/1ps
module rpt_alarm_bench;

    logic clk = 1'b0;
    logic rst_n;
    always #10 clk = ~clk;

    // stimulus kept as integers, presented in BCD
    int t_half, t_sec, t_min, t_hour, t_wday, t_day, t_mon;
    int a_sec, a_min, a_hour, a_wday, a_day, a_mon;
    logic tick, set_wr, cfg_wr, cfg_en, cfg_chime;
    logic [3:0] cfg_mask;
    logic [7:0] cfg_rpt;
    logic irq, alm_pulse, en_o;
    logic [7:0] rpt_o;

    function automatic logic [7:0] bcd(int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    rpt_alarm u_rpt_alarm (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .now_half(t_half[0]), .now_sec(bcd(t_sec)), .now_min(bcd(t_min)),
        .now_hour(bcd(t_hour)), .now_wday(3'(t_wday)), .now_day(bcd(t_day)),
        .now_month(bcd(t_mon)),
        .set_wr(set_wr), .set_sec(bcd(a_sec)), .set_min(bcd(a_min)),
        .set_hour(bcd(a_hour)), .set_wday(3'(a_wday)), .set_day(bcd(a_day)),
        .set_month(bcd(a_mon)),
        .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_mask(cfg_mask), .cfg_rpt(cfg_rpt),
        .cfg_chime(cfg_chime),
        .irq(irq), .alm_pulse(alm_pulse), .en_o(en_o), .rpt_o(rpt_o)
    );

    // ---------------- behavioural reference ----------------
    int m_en, m_rpt, m_chime, m_mask, m_irq, m_pulse;
    int v_sec, v_min, v_hour, v_wday, v_day, v_mon;

    function automatic bit ref_match(int code);
        bit base = (t_half == 0);
        case (code)
            0: return 1;
            1: return base;
            2: return base && (t_sec % 10 == v_sec % 10);
            3: return base && (t_sec == v_sec);
            4: return base && (t_sec == v_sec) && (t_min % 10 == v_min % 10);
            5: return base && (t_sec == v_sec) && (t_min == v_min);
            6: return base && (t_sec == v_sec) && (t_min == v_min) && (t_hour == v_hour);
            7: return base && (t_sec == v_sec) && (t_min == v_min) && (t_hour == v_hour)
                      && (t_wday == v_wday);
            8: return base && (t_sec == v_sec) && (t_min == v_min) && (t_hour == v_hour)
                      && (t_day == v_day);
            9: return base && (t_sec == v_sec) && (t_min == v_min) && (t_hour == v_hour)
                      && (t_day == v_day) && (t_mon == v_mon);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_rpt = 0; m_chime = 0; m_mask = 0; m_irq = 0; m_pulse = 0;
            v_sec = 0; v_min = 0; v_hour = 0; v_wday = 0; v_day = 0; v_mon = 0;
        end else begin
            bit ev;
            ev = (m_en == 1) && tick && ref_match(m_mask);
            m_irq = ev ? 1 : 0;
            if (set_wr && m_en == 0) begin
                v_sec = a_sec; v_min = a_min; v_hour = a_hour;
                v_wday = a_wday; v_day = a_day; v_mon = a_mon;
            end
            if (cfg_wr) begin
                m_rpt = cfg_rpt; m_mask = cfg_mask; m_chime = cfg_chime;
                if (!cfg_en) begin m_en = 0; m_pulse = 0; end
                else if (m_en == 0) begin m_en = 1; m_pulse = 0; end
                else if (ev) m_pulse = 1 - m_pulse;
            end else if (ev) begin
                if (m_rpt > 0) begin m_rpt--; m_pulse = 1 - m_pulse; end
                else if (m_chime != 0) begin m_rpt = 255; m_pulse = 1 - m_pulse; end
                else begin m_en = 0; m_pulse = 0; end
            end
        end
    end

    // ---------------- checking ----------------
    int n_cmp = 0, n_bad = 0, n_irq = 0;
    string phase = "R1";
    bit done = 0;

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(irq == m_irq[0], {phase, " irq"}, int'(irq), m_irq);
            check(alm_pulse == m_pulse[0], {phase, " alm_pulse"}, int'(alm_pulse), m_pulse);
            check(en_o == m_en[0], {phase, " en_o"}, int'(en_o), m_en);
            check(int'(rpt_o) == m_rpt, {phase, " rpt_o"}, int'(rpt_o), m_rpt);
            if (irq) n_irq++;
        end
    end

    task automatic step();
        @(posedge clk); #5;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic do_cfg(bit en, int rpt, bit chime, int mask);
        cfg_en = en; cfg_rpt = 8'(rpt); cfg_chime = chime; cfg_mask = 4'(mask);
        cfg_wr = 1; step(); cfg_wr = 0;
    endtask

    task automatic do_set(int s, int mi, int h, int wd, int d, int mo);
        a_sec = s; a_min = mi; a_hour = h; a_wday = wd; a_day = d; a_mon = mo;
        set_wr = 1; step(); set_wr = 0;
    endtask

    task automatic now_is(int hf, int s, int mi, int h, int wd, int d, int mo);
        t_half = hf; t_sec = s; t_min = mi; t_hour = h; t_wday = wd; t_day = d; t_mon = mo;
    endtask

    task automatic do_tick();
        tick = 1; step(); tick = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0 (run hung)");
            summary();
        end
    end

    initial begin
        int base_n;
        rst_n = 0; tick = 0; set_wr = 0; cfg_wr = 0; cfg_en = 0; cfg_mask = 0;
        cfg_rpt = 0; cfg_chime = 0;
        now_is(0, 0, 0, 0, 0, 1, 1);
        a_sec = 0; a_min = 0; a_hour = 0; a_wday = 0; a_day = 0; a_mon = 0;
        repeat (3) step();
        settle();
        check(!en_o && rpt_o == 0 && !irq && !alm_pulse, "R1 reset idle", int'(en_o), 0);
        rst_n = 1; step();

        // R3 / R4: each mask code, matching and broken fields (chime keeps it armed)
        phase = "R3";
        for (int code = 0; code < 16; code++) begin
            do_cfg(0, 5, 1, code);
            do_set(37, 24, 13, 4, 19, 7);
            do_cfg(1, 5, 1, code);
            now_is(0, 37, 24, 13, 4, 19, 7);
            base_n = n_irq;
            do_tick(); settle();
            if (code <= 9) check(n_irq == base_n + 1, "R3 full match", n_irq - base_n, 1);
            else           check(n_irq == base_n,     "R4 illegal code", n_irq - base_n, 0);
            step();
            if (code >= 1 && code <= 9) begin
                case (code)
                    1: now_is(1, 37, 24, 13, 4, 19, 7);
                    2: now_is(0, 38, 24, 13, 4, 19, 7);
                    3: now_is(0, 47, 24, 13, 4, 19, 7);
                    4: now_is(0, 37, 25, 13, 4, 19, 7);
                    5: now_is(0, 37, 34, 13, 4, 19, 7);
                    6: now_is(0, 37, 24, 14, 4, 19, 7);
                    7: now_is(0, 37, 24, 13, 5, 19, 7);
                    8: now_is(0, 37, 24, 13, 4, 20, 7);
                    default: now_is(0, 37, 24, 13, 4, 19, 8);
                endcase
                base_n = n_irq;
                do_tick(); settle();
                check(n_irq == base_n, "R3 broken field", n_irq - base_n, 0);
                step();
            end
        end
        // monthly ignores weekday; ten-second ignores the tens digit
        do_cfg(0, 5, 1, 8); do_cfg(1, 5, 1, 8);
        now_is(0, 37, 24, 13, 2, 19, 7);
        base_n = n_irq; do_tick(); settle();
        check(n_irq == base_n + 1, "R3 monthly ignores weekday", n_irq - base_n, 1);
        step();
        do_cfg(1, 5, 1, 2);
        now_is(0, 57, 0, 0, 0, 1, 1);
        base_n = n_irq; do_tick(); settle();
        check(n_irq == base_n + 1, "R3 ten-second ones only", n_irq - base_n, 1);
        step();

        // R5 / R6 / R8: count 2, chime off, every tick
        phase = "R5";
        do_cfg(0, 0, 0, 0);
        do_cfg(1, 2, 0, 0);
        settle();
        check(!alm_pulse && en_o && rpt_o == 2, "R10 armed fresh", int'(rpt_o), 2);
        step();
        do_tick(); settle();
        check(rpt_o == 1 && alm_pulse && irq, "R5 first decrement", int'(rpt_o), 1);
        step(); settle();
        check(!irq, "R2 irq one cycle", int'(irq), 0);
        step();
        do_tick(); settle();
        check(rpt_o == 0 && !alm_pulse, "R8 second toggle", int'(alm_pulse), 0);
        step();
        phase = "R6";
        do_tick(); settle();
        check(irq && !en_o && rpt_o == 0 && !alm_pulse, "R6 final event", int'(en_o), 0);
        step();
        base_n = n_irq; do_tick(); settle();
        check(n_irq == base_n, "R6 disarmed stays quiet", n_irq - base_n, 0);
        step();

        // R7: chime wrap
        phase = "R7";
        do_cfg(1, 0, 1, 0);
        do_tick(); settle();
        check(rpt_o == 8'hFF && en_o && alm_pulse, "R7 wrap to FF", int'(rpt_o), 255);
        step();
        do_tick(); settle();
        check(rpt_o == 8'hFE && en_o, "R7 keeps counting", int'(rpt_o), 254);
        step();

        // R10: count rewritten while armed
        phase = "R10";
        do_cfg(1, 9, 1, 3);
        settle();
        check(rpt_o == 9 && en_o, "R10 live count write", int'(rpt_o), 9);
        step();

        // R9: alarm-time write ignored while armed
        phase = "R9";
        do_cfg(0, 3, 1, 3);
        do_set(30, 0, 0, 0, 1, 1);
        do_cfg(1, 3, 1, 3);
        do_set(45, 0, 0, 0, 1, 1);
        now_is(0, 45, 0, 0, 0, 1, 1);
        base_n = n_irq; do_tick(); settle();
        check(n_irq == base_n, "R9 ignored value", n_irq - base_n, 0);
        step();
        now_is(0, 30, 0, 0, 0, 1, 1);
        base_n = n_irq; do_tick(); settle();
        check(n_irq == base_n + 1, "R9 stored value kept", n_irq - base_n, 1);
        step();

        // R11: matching time held, tick only once
        phase = "R11";
        base_n = n_irq;
        repeat (5) step();
        settle();
        check(n_irq == base_n, "R11 no tick no event", n_irq - base_n, 0);
        step();
        do_tick();
        repeat (4) step();
        settle();
        check(n_irq == base_n + 1, "R11 one event per tick", n_irq - base_n, 1);
        step();

        phase = "R2";
        do_cfg(0, 0, 0, 0);
        repeat (3) step();
        settle();
        done = 1;
        summary();
    end

endmodule